// File: doc/BRIEF.md
# GPIO Port with Atomic Bit Set and Clear

This block is a memory-mapped general-purpose I/O port. It holds one output-latch bit for each pin. Software can change that latch in three ways. It can load the whole latch through a data register. It can raise selected bits through a set alias. It can lower selected bits through a clear alias. The set and clear aliases change only the bits written as one. Several independent software tasks can therefore drive their own pins with no read-modify-write sequence and no critical section.

A direction register selects input or output mode for each pin. A bit value of 1 means input. Every pin comes out of reset as an input. Each pin's output enable is the inverse of its direction bit. The latch reaches a pin only while that pin is in output mode. A separate read-only register reports the real pin levels after a two-flop synchronizer. This value can differ from the latch, for example on a pin that is configured as an input.

The register bus is plain: a byte address, a write strobe, write data, and read data. Read data is combinational from the address. A write takes effect at the clock edge where the strobe is high. No interface carries a stream, so the port has no valid/ready handshake and no back-pressure.

Top module: `gpio_setclr_port`

## Requirements
- R1: After reset, the direction register reads all ones, so every pin is an input. The output latch reads zero. Every output enable and every pin output is 0.
- R2: A write to byte offset 0x04 (output data) loads the complete written value into the output latch. The value is visible at the edge that takes the write.
- R3: A write to byte offset 0x08 (set alias) forces each latch bit whose write bit is 1 to 1. Latch bits whose write bit is 0 keep their value.
- R4: A write to byte offset 0x0C (clear alias) forces each latch bit whose write bit is 1 to 0. Latch bits whose write bit is 0 keep their value.
- R5: A read of offset 0x08 or offset 0x0C returns the present output latch, not the last value written there. A read of 0x04 also returns the latch.
- R6: Offset 0x00 (direction) can be written and read back. For each pin, the output enable equals the inverse of that pin's direction bit (1 = input, 0 = output).
- R7: Offset 0x10 (pin levels) returns the pin inputs delayed by exactly two clock edges.
- R8: A write to offset 0x10 changes no register. An address that is not mapped reads as zero, and a write to it changes nothing.
- R9: A pin's output value equals its latch bit while the pin is in output mode. It is 0 while the pin is in input mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 5 | Byte address of the register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| pin_in | input | 16 | Pin levels from the pads |
| pin_out | output | 16 | Pin output values |
| pin_oe | output | 16 | Per-pin output enables |

## Verification
Writes to the latch or to the direction register show on bus_rdata, pin_out and pin_oe right after the edge that takes the write. The bench applies each write at a falling edge and checks the outputs at the next falling edge. A change on pin_in reaches the pin-level register only at the second rising edge. The bench therefore checks after one edge that the old value is still present, and after the second edge that the new value has arrived. Reads are combinational, so each read is sampled a fraction of a cycle after the address changes, well away from any clock edge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  // Word index of each register (byte address bits [4:2]); the map is fixed.
  typedef enum logic [2:0] {
    IDX_DIR  = 3'd0,
    IDX_DATA = 3'd1,
    IDX_SET  = 3'd2,
    IDX_CLR  = 3'd3,
    IDX_PINS = 3'd4
  } reg_idx_e;

  typedef struct packed {
    logic dir;
    logic data;
    logic set;
    logic clr;
  } wr_sel_t;

  function automatic wr_sel_t decode_write(input logic we, input logic [2:0] idx);
    wr_sel_t s;
    s.dir  = we && (idx == IDX_DIR);
    s.data = we && (idx == IDX_DATA);
    s.set  = we && (idx == IDX_SET);
    s.clr  = we && (idx == IDX_CLR);
    return s;
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= pin_i;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];

  // Checker: enable the two-edge comparison only after two edges out of reset.
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  p_two_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (STAGES == 2 && age_q >= 2'd2) |-> (sync_o == $past(pin_i, 2)));
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] latch_o
);
  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     latch_o[b] <= 1'b0;
        else if (load_i)                latch_o[b] <= wdata_i[b];
        else if (set_i && wdata_i[b])   latch_o[b] <= 1'b1;
        else if (clr_i && wdata_i[b])   latch_o[b] <= 1'b0;
      end
    end
  endgenerate

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (latch_o == $past(wdata_i)));
  p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> (latch_o == ($past(latch_o) | $past(wdata_i))));
  p_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (latch_o == ($past(latch_o) & ~$past(wdata_i))));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_i || set_i || clr_i) |=> $stable(latch_o));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int WIDTH  = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              dir_we_i,
  input  logic [WIDTH-1:0]  wdata_i,
  input  logic [WIDTH-1:0]  latch_i,
  input  logic [WIDTH-1:0]  pins_i,
  output logic [WIDTH-1:0]  dir_o,
  output logic [WIDTH-1:0]  rdata_o
);
  import gpio_pkg::*;

  localparam int IDX_LSB = 2;
  localparam int HI_W    = ADDR_W - IDX_LSB - 3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dir_o <= '1;
    else if (dir_we_i) dir_o <= wdata_i;
  end

  logic [2:0] idx;
  logic       in_range;
  assign idx = addr_i[IDX_LSB +: 3];
  generate
    if (HI_W > 0) begin : g_hi
      assign in_range = (addr_i[ADDR_W-1 -: ((HI_W > 0) ? HI_W : 1)] == '0);
    end else begin : g_nohi
      assign in_range = 1'b1;
    end
  endgenerate

  always_comb begin
    rdata_o = '0;
    if (in_range) begin
      unique case (idx)
        IDX_DIR:                    rdata_o = dir_o;
        IDX_DATA, IDX_SET, IDX_CLR: rdata_o = latch_i;
        IDX_PINS:                   rdata_o = pins_i;
        default:                    rdata_o = '0;
      endcase
    end
  end

  p_dir_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dir_we_i |=> (dir_o == $past(wdata_i)));
endmodule

// File: rtl/gpio_setclr_port.sv
module gpio_setclr_port #(
  parameter int WIDTH  = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe
);
  import gpio_pkg::*;

  localparam int HI_W = ADDR_W - 5;

  logic       addr_ok;
  wr_sel_t    wsel;
  logic [WIDTH-1:0] latch, dir, pins_sync;

  generate
    if (HI_W > 0) begin : g_hi
      assign addr_ok = (bus_addr[ADDR_W-1 -: ((HI_W > 0) ? HI_W : 1)] == '0);
    end else begin : g_nohi
      assign addr_ok = 1'b1;
    end
  endgenerate

  assign wsel = decode_write(bus_we && addr_ok, bus_addr[4:2]);

  gpio_in_sync #(.WIDTH(WIDTH), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_in), .sync_o(pins_sync)
  );

  gpio_out_latch #(.WIDTH(WIDTH)) u_latch (
    .clk(clk), .rst_n(rst_n),
    .load_i(wsel.data), .set_i(wsel.set), .clr_i(wsel.clr),
    .wdata_i(bus_wdata), .latch_o(latch)
  );

  gpio_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr_i(bus_addr), .dir_we_i(wsel.dir),
    .wdata_i(bus_wdata), .latch_i(latch), .pins_i(pins_sync),
    .dir_o(dir), .rdata_o(bus_rdata)
  );

  assign pin_oe  = ~dir;
  assign pin_out = latch & ~dir;

  p_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0);
  p_reset_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (pin_oe == '0 && pin_out == '0));
endmodule

// File: tb/test_gpio_setclr_port.sv
module test_gpio_setclr_port;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk = 0, rst_n = 0, bus_we = 0;
  logic [4:0] bus_addr = '0;
  logic [W-1:0] bus_wdata = '0, pin_in = '0;
  logic [W-1:0] bus_rdata, pin_out, pin_oe;
  int checks = 0, errors = 0;
  logic done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_setclr_port i_gpio_setclr_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [W-1:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    rd(5'h00, v); chk("R1 dir", v, 16'hFFFF);
    rd(5'h04, v); chk("R1 latch", v, 16'h0000);
    chk("R1 oe", pin_oe, 16'h0000);
    chk("R1 out", pin_out, 16'h0000);
  endtask

  task automatic t_load_dir();
    logic [W-1:0] v;
    wr(5'h04, 16'hA5C3);
    rd(5'h04, v); chk("R2 load", v, 16'hA5C3);
    chk("R9 input pins gated", pin_out, 16'h0000);
    wr(5'h00, 16'h00FF);
    rd(5'h00, v); chk("R6 dir readback", v, 16'h00FF);
    chk("R6 oe", pin_oe, 16'hFF00);
    chk("R9 out", pin_out, 16'hA500);
  endtask

  task automatic t_set();
    logic [W-1:0] v;
    wr(5'h04, 16'h0000);
    wr(5'h08, 16'h0048);
    rd(5'h04, v); chk("R3 set", v, 16'h0048);
    wr(5'h08, 16'h1001);
    rd(5'h04, v); chk("R3 set keeps", v, 16'h1049);
  endtask

  task automatic t_clr();
    logic [W-1:0] v;
    wr(5'h0C, 16'h0041);
    rd(5'h04, v); chk("R4 clear", v, 16'h1008);
    chk("R9 out after clear", pin_out, 16'h1000);
  endtask

  task automatic t_alias();
    logic [W-1:0] v;
    rd(5'h08, v); chk("R5 set alias read", v, 16'h1008);
    rd(5'h0C, v); chk("R5 clear alias read", v, 16'h1008);
  endtask

  task automatic t_pins();
    logic [W-1:0] v;
    @(negedge clk); pin_in = 16'h3C3C;
    @(negedge clk);
    rd(5'h10, v); chk("R7 one edge", v, 16'h0000);
    @(negedge clk);
    rd(5'h10, v); chk("R7 two edges", v, 16'h3C3C);
  endtask

  task automatic t_ro();
    logic [W-1:0] v;
    wr(5'h10, 16'hFFFF);
    rd(5'h10, v); chk("R8 pins read-only", v, 16'h3C3C);
    rd(5'h04, v); chk("R8 latch untouched", v, 16'h1008);
    rd(5'h00, v); chk("R8 dir untouched", v, 16'h00FF);
    wr(5'h14, 16'hFFFF);
    rd(5'h14, v); chk("R8 unmapped reads zero", v, 16'h0000);
    rd(5'h04, v); chk("R8 latch after unmapped", v, 16'h1008);
    rd(5'h00, v); chk("R8 dir after unmapped", v, 16'h00FF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_load_dir();
    t_set();
    t_clr();
    t_alias();
    t_pins();
    t_ro();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule